// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Model

This block is a synthesizable, cycle-accurate model of a synchronous static RAM whose data bus never needs an idle cycle between a read and a write. It holds its contents in an internal register array. Address, chip enables, the write command, the byte-lane enables and the advance/load command are all captured on the rising clock edge. Write data follows its address later on the same shared timeline. The model keeps each write pending until its data arrives, and any read that overlaps it sees the merged result. Because of this, read, write and read commands can sit on consecutive clock edges without stalling.

A static mode input picks one of two timings. In pipelined mode, read data passes through an output register. In flow-through mode, read data comes straight from the array. Accesses are four-beat bursts. A load starts a burst and an advance continues it. A static order input picks linear or interleaved beat sequencing. The data outputs can be switched off at any moment by an asynchronous output enable. A sleep input suspends command handling and leaves the stored contents untouched. Instead of a tristate pin, the data outputs come as a value plus a drive qualifier.

Top module: `zt_sram`

## Requirements
- R1: After a synchronous reset (`rst_n` low on a rising edge), `dq_drive` is 0 and `dq_out` is all zeros until a new read is issued.
- R2: In pipelined mode (`flow_mode`=0), a read loaded on rising edge n is not driven after edge n. Its data is driven on `dq_out` after edge n+1 and before edge n+2.
- R3: In flow-through mode (`flow_mode`=1), a read loaded on rising edge n is driven on `dq_out` after edge n, with no further edge needed.
- R4: The write data for a command on edge n is sampled from `wdata` at edge n+2 in pipelined mode and at edge n+1 in flow-through mode.
- R5: Read, write and read commands on consecutive edges all complete with no idle cycle. A read of an address whose write data has not yet been stored returns the new data.
- R6: Lane i covers data bits [9i+8:9i]. A write changes only the lanes whose `byte_en` bit is 1. A read that overlaps a pending write merges the pending lanes with the stored lanes.
- R7: A load takes effect only when `ce_a`, `ce_b` and `ce_c` are all 1. Otherwise the cycle is a deselect: nothing is written and nothing is driven.
- R8: With `interleave`=0, beat k (k=0..3) of a burst loaded at address A uses low address bits (A[1:0]+k) mod 4, with the upper bits unchanged.
- R9: With `interleave`=1, beat k uses low address bits A[1:0] XOR k, with the upper bits unchanged.
- R10: When `oe` is 0, `dq_drive` is 0 and `dq_out` is zero at once, without waiting for a clock edge.
- R11: While `sleep` is 1, commands on the clock edge are ignored and the array keeps its contents. `dq_drive` is 0 for as long as `sleep` is 1.
- R12: An advance (`advance`=1) when no burst is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the control pipeline |
| flow_mode | input | 1 | Static: 1 for flow-through, 0 for pipelined |
| interleave | input | 1 | Static burst order: 1 for interleaved, 0 for linear |
| ce_a | input | 1 | Chip enable, active high |
| ce_b | input | 1 | Chip enable, active high |
| ce_c | input | 1 | Chip enable, active high |
| advance | input | 1 | 1 continues the current burst, 0 loads a new access |
| we | input | 1 | On a load: 1 for write, 0 for read |
| byte_en | input | LANES | Per-lane write enable, sampled with each beat |
| addr | input | ADDR_W | Word address, sampled on a load |
| wdata | input | LANES*LANE_W | Late write data |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Power-down: ignore commands, hold contents |
| dq_out | output | LANES*LANE_W | Read data, zero when not driven |
| dq_drive | output | 1 | High when `dq_out` is actively driven |

## Verification
The bench targets the pipelined read that lands on the same edge as the stored data of an earlier write to the same address. Without forwarding, such a design returns the stale word. With the wrong lane merge, it returns a word where the disabled lane is overwritten. It checks that pipelined and flow-through latencies, and the matching write-data lags, are exactly one edge apart. An off-by-one design would drive data a cycle early or late, or would store whatever happened to be on the bus. Interleaved bursts are started from an odd low address so that they differ from linear order. The bench also confirms at the outputs that partial chip enables, sleep and a stray advance leave both the array and the bus untouched.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flow_mode,
  input  logic              interleave,
  input  logic              ce_a,
  input  logic              ce_b,
  input  logic              ce_c,
  input  logic              advance,
  input  logic              we,
  input  logic [LANES-1:0]  byte_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              oe,
  input  logic              sleep,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_drive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic              b_act, b_we;
  logic [ADDR_W-1:0] b_base;
  logic [1:0]        b_cnt;

  logic              s1_v, s1_we, s2_v, s2_we, o_v;
  logic [ADDR_W-1:0] s1_a, s2_a;
  logic [LANES-1:0]  s1_be, s2_be;
  logic [DATA_W-1:0] o_d, rd_m;

  wire              sel    = ce_a & ce_b & ce_c;
  wire              ld_go  = !sleep && !advance && sel;
  wire              adv_go = !sleep && advance && b_act;
  wire              issue  = ld_go || adv_go;
  wire [1:0]        cnt_n  = ld_go ? 2'd0 : b_cnt + 2'd1;
  wire [ADDR_W-1:0] base_n = ld_go ? addr : b_base;
  wire              we_n   = ld_go ? we : b_we;
  wire [1:0]        low_n  = interleave ? (base_n[1:0] ^ cnt_n) : (base_n[1:0] + cnt_n);
  wire [ADDR_W-1:0] eff_a  = {base_n[ADDR_W-1:2], low_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_act  <= 1'b0;
      b_we   <= 1'b0;
      b_base <= '0;
      b_cnt  <= '0;
    end else if (!sleep) begin
      if (!advance) b_act <= sel;
      if (issue) begin
        b_base <= base_n;
        b_cnt  <= cnt_n;
        b_we   <= we_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v  <= 1'b0;
      s1_we <= 1'b0;
      s1_a  <= '0;
      s1_be <= '0;
      s2_v  <= 1'b0;
      s2_we <= 1'b0;
      s2_a  <= '0;
      s2_be <= '0;
      o_v   <= 1'b0;
      o_d   <= '0;
    end else begin
      s1_v  <= issue;
      s1_we <= we_n;
      s1_a  <= eff_a;
      s1_be <= byte_en;
      s2_v  <= s1_v;
      s2_we <= s1_we;
      s2_a  <= s1_a;
      s2_be <= s1_be;
      o_v   <= s1_v && !s1_we;
      o_d   <= rd_m;
    end
  end

  wire              c_v  = flow_mode ? (s1_v && s1_we) : (s2_v && s2_we);
  wire [ADDR_W-1:0] c_a  = flow_mode ? s1_a : s2_a;
  wire [LANES-1:0]  c_be = flow_mode ? s1_be : s2_be;

  always_ff @(posedge clk) begin
    if (c_v) begin
      for (int i = 0; i < LANES; i++)
        if (c_be[i]) mem[c_a][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
    end
  end

  wire fwd = !flow_mode && s2_v && s2_we && (s2_a == s1_a);

  always_comb begin
    rd_m = mem[s1_a];
    for (int i = 0; i < LANES; i++)
      if (fwd && s2_be[i]) rd_m[i*LANE_W +: LANE_W] = wdata[i*LANE_W +: LANE_W];
  end

  wire              data_v = flow_mode ? (s1_v && !s1_we) : o_v;
  wire [DATA_W-1:0] data   = flow_mode ? rd_m : o_d;

  assign dq_drive = data_v && oe && !sleep;
  assign dq_out   = dq_drive ? data : '0;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flow_mode,
  input logic              ce_a,
  input logic              ce_b,
  input logic              ce_c,
  input logic              advance,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic              oe,
  input logic              sleep,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_drive
);
  wire all_ce  = ce_a && ce_b && ce_c;
  wire rd_load = !sleep && !advance && !we && all_ce;
  wire desel   = !sleep && !advance && !all_ce;

  a_r1_quiet_after_reset: assert property (@(posedge clk) !rst_n |=> !dq_drive);

  a_r3_flow_read_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    flow_mode && rd_load |=> (dq_drive || !oe || sleep));

  a_r2_pipe_read_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !flow_mode && rd_load |=> !dq_drive ##1 (dq_drive || !oe || sleep));

  a_r7_flow_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flow_mode && desel |=> !dq_drive);

  a_r7_pipe_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !flow_mode && desel |=> ##1 !dq_drive);

  a_r10_undriven_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_drive |-> dq_out == '0);

  a_r11_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_drive);

  a_r10_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !dq_drive);

  wire unused_ok = ^addr;
endmodule

bind zt_sram zt_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .ce_a(ce_a), .ce_b(ce_b),
  .ce_c(ce_c), .advance(advance), .we(we), .addr(addr), .oe(oe), .sleep(sleep),
  .dq_out(dq_out), .dq_drive(dq_drive));

// File: tb/zt_sram_tb_top.sv
module zt_sram_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, flow_mode = 0, interleave = 0;
  logic ce_a = 0, ce_b = 0, ce_c = 0, advance = 0, we = 0, oe = 1, sleep = 0;
  logic [1:0]  byte_en = 0;
  logic [5:0]  addr = 0;
  logic [17:0] wdata = 0, dq_out;
  logic        dq_drive;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zt_sram dut_i (.clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .interleave(interleave),
    .ce_a(ce_a), .ce_b(ce_b), .ce_c(ce_c), .advance(advance), .we(we), .byte_en(byte_en),
    .addr(addr), .wdata(wdata), .oe(oe), .sleep(sleep), .dq_out(dq_out), .dq_drive(dq_drive));

  task automatic chk(input string r, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic tick(input logic ad, input logic w, input logic [2:0] ce,
                      input logic [5:0] a, input logic [1:0] be, input logic [17:0] d);
    advance = ad; we = w; {ce_a, ce_b, ce_c} = ce; addr = a; byte_en = be; wdata = d;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic nop(input logic [17:0] d); tick(0, 0, 3'b000, 0, 0, d); endtask

  task automatic do_reset(input logic mode);
    rst_n = 0; flow_mode = mode; interleave = 0; oe = 1; sleep = 0;
    nop(0); nop(0);
    rst_n = 1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [1:0] be, input logic [17:0] d);
    tick(0, 1, 3'b111, a, be, 0);
    if (!flow_mode) nop(0);
    nop(d);
  endtask

  task automatic rd(input logic [5:0] a, output logic [17:0] d, output logic drv);
    tick(0, 0, 3'b111, a, 0, 0);
    if (!flow_mode) nop(0);
    d = dq_out; drv = dq_drive;
    nop(0);
  endtask

  task automatic t_reset_state;
    do_reset(0);
    chk("R1 drive", dq_drive, 0);
    chk("R1 data", dq_out, 0);
  endtask

  task automatic t_pipe_latency;
    wr(6'd1, 2'b11, 18'h15A5A);
    tick(0, 0, 3'b111, 6'd1, 0, 0);
    chk("R2 not yet driven", dq_drive, 0);
    nop(0);
    chk("R2 driven", dq_drive, 1);
    chk("R2 data", dq_out, 18'h15A5A);
    nop(0);
  endtask

  task automatic t_pipe_rwr;
    logic [17:0] d; logic v;
    wr(6'd3, 2'b11, 18'h2AB55);
    tick(0, 1, 3'b111, 6'd2, 2'b11, 0);
    tick(0, 0, 3'b111, 6'd2, 0, 0);
    tick(0, 1, 3'b111, 6'd3, 2'b01, 18'h1C3A5);
    chk("R5 pipe pending fwd", dq_out, 18'h1C3A5);
    tick(0, 0, 3'b111, 6'd3, 0, 0);
    chk("R4 pipe write idle bus", dq_drive, 0);
    nop(18'h3F0F0);
    chk("R6 pipe lane merge", dq_out, {18'h2AB55 >> 9, 9'h0F0});
    rd(6'd2, d, v);
    chk("R4 pipe stored late data", d, 18'h1C3A5);
    rd(6'd3, d, v);
    chk("R6 pipe stored lanes", d, {18'h2AB55 >> 9, 9'h0F0});
  endtask

  task automatic t_flow_latency;
    logic [17:0] d; logic v;
    do_reset(1);
    wr(6'd1, 2'b11, 18'h0BEEF);
    tick(0, 0, 3'b111, 6'd1, 0, 0);
    chk("R3 flow driven", dq_drive, 1);
    chk("R3 flow data", dq_out, 18'h0BEEF);
    nop(0);
    rd(6'd1, d, v);
    chk("R4 flow lag", d, 18'h0BEEF);
  endtask

  task automatic t_flow_rwr;
    wr(6'd5, 2'b11, 18'h12345);
    tick(0, 1, 3'b111, 6'd4, 2'b11, 0);
    tick(0, 0, 3'b111, 6'd4, 0, 18'h3C3C3);
    chk("R5 flow read after write", dq_out, 18'h3C3C3);
    tick(0, 1, 3'b111, 6'd5, 2'b10, 0);
    tick(0, 0, 3'b111, 6'd5, 0, 18'h2FFAA);
    chk("R6 flow upper lane only", dq_out, {18'h2FFAA >> 9, 9'h145});
    nop(0);
  endtask

  task automatic t_burst(input logic il);
    for (int i = 0; i < 4; i++) wr(6'(8 + i), 2'b11, 18'(18'h100 + i));
    interleave = il;
    for (int k = 0; k < 4; k++) begin
      logic [1:0] lo;
      lo = il ? (2'b01 ^ 2'(k)) : 2'(1 + k);
      tick(k != 0, 0, 3'b111, 6'd9, 0, 0);
      chk(il ? "R9 interleaved beat" : "R8 linear beat", dq_out, 18'(18'h100 + lo));
    end
    nop(0);
    interleave = 0;
  endtask

  task automatic t_adv_idle;
    logic [17:0] d; logic v;
    do_reset(1);
    wr(6'd7, 2'b11, 18'h00777);
    nop(0);
    tick(1, 1, 3'b111, 6'd7, 2'b11, 0);
    nop(18'h3FFFF);
    chk("R12 stray advance no write", dq_drive, 0);
    rd(6'd7, d, v);
    chk("R12 contents kept", d, 18'h00777);
  endtask

  task automatic t_chip_enables;
    logic [17:0] d; logic v;
    wr(6'd12, 2'b11, 18'h0AAAA);
    tick(0, 1, 3'b110, 6'd12, 2'b11, 0);
    nop(18'h11111);
    tick(0, 1, 3'b101, 6'd12, 2'b11, 0);
    nop(18'h22222);
    rd(6'd12, d, v);
    chk("R7 partial enable no write", d, 18'h0AAAA);
    tick(0, 0, 3'b011, 6'd12, 0, 0);
    chk("R7 partial enable no drive", dq_drive, 0);
    nop(0);
  endtask

  task automatic t_oe;
    wr(6'd14, 2'b11, 18'h13579);
    tick(0, 0, 3'b111, 6'd14, 0, 0);
    oe = 0; #1;
    chk("R10 oe off drive", dq_drive, 0);
    chk("R10 oe off data", dq_out, 0);
    oe = 1; #1;
    chk("R10 oe back on", dq_out, 18'h13579);
    nop(0);
  endtask

  task automatic t_sleep;
    logic [17:0] d; logic v;
    wr(6'd13, 2'b11, 18'h0C0DE);
    sleep = 1;
    tick(0, 1, 3'b111, 6'd13, 2'b11, 0);
    nop(18'h3DEAD);
    tick(0, 0, 3'b111, 6'd13, 0, 0);
    chk("R11 no drive in sleep", dq_drive, 0);
    sleep = 0; #1;
    chk("R11 read during sleep ignored", dq_drive, 0);
    nop(0);
    rd(6'd13, d, v);
    chk("R11 contents kept", d, 18'h0C0DE);
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_pipe_latency();
    t_pipe_rwr();
    t_flow_latency();
    t_flow_rwr();
    t_burst(0);
    t_burst(1);
    t_adv_idle();
    t_chip_enables();
    t_oe();
    t_sleep();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule